// File: doc/BRIEF.md
# Six-Step Commutation PWM Unit

This unit drives the six gates of a three-phase bridge for trapezoidal brushless motor control. An up-counting carrier and a single shared compare threshold give an edge-aligned PWM. A six-entry commutation table picks one phase whose high-side gate carries that PWM, and a second phase whose low-side gate is held solidly on. Every gate's turn-on is delayed by a programmable dead time, so no high-side and low-side pair of the same phase can overlap.

Control software loads the next step with an advance strobe. The step pointer moves forward and the gate selection for the new step is placed in a shadow register. A separate commutation strobe then copies that selection to the active set in one clock. Period and compare values are also preloaded. They are taken at the carrier wrap, or at once on a forced update. All gates stay low unless both the run enable and the master output enable are high.

Top module: `sixstep_pwm`

## Requirements
- R1: The carrier counts 0, 1, … up to the active period value P and then returns to 0, so one PWM cycle lasts P+1 clocks. It is held at 0 while run_en is low.
- R2: The PWM reference is high while the carrier is below the active compare value C. With zero dead time, the enabled high-side gate is high for C clocks per cycle: never when C = 0, and in every clock when C > P.
- R3: period_in and duty_in are taken into the active period and compare only at a carrier wrap (the clock in which the count equals P) or in a clock where force_upd is high. A compare change in mid-cycle therefore leaves the current cycle's on-time unchanged.
- R4: The steps run in the order index 0 to 5. Using phase bits A = bit 0, B = bit 1, C = bit 2, the (high, low) pairs are (A,B), (A,C), (B,C), (B,A), (C,A), (C,B).
- R5: In every step exactly one high-side gate and one low-side gate are enabled, and they belong to different phases. The low-side gate of the phase driven high is never asserted, and no gate carries a complement of the PWM.
- R6: The enabled low-side gate is held high continuously, not pulsed with the PWM.
- R7: step_adv moves the step pointer and loads the shadow selection, but leaves the gates unchanged. The active selection changes only in the clock after a commute strobe.
- R8: The step pointer wraps from index 5 back to index 0.
- R9: Each gate rises dead_in clocks after its request rises and falls in the same clock as its request. The high-side on-time per cycle is therefore max(0, C − dead_in). When commutation moves a phase from high to low, its low-side gate stays off for dead_in clocks after the high-side gate falls.
- R10: When moe or run_en is low, all six gates are low in that same clock.
- R11: After reset the carrier is 0, the pointer is at index 0 with the shadow holding step 0, and the active selection is empty. No gate rises before the first commute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Carrier run enable |
| moe | input | 1 | Master output enable |
| period_in | input | CNT_W | Preload period value P |
| duty_in | input | CNT_W | Preload compare value C |
| dead_in | input | DT_W | Dead time in clocks |
| force_upd | input | 1 | Forced transfer of period and compare |
| step_adv | input | 1 | Advance step pointer and load shadow |
| commute | input | 1 | Copy shadow selection to active |
| gate_hi | output | 3 | High-side gates, bit 0 = A, 1 = B, 2 = C |
| gate_lo | output | 3 | Low-side gates, bit 0 = A, 1 = B, 2 = C |

## Verification
A table of period, compare and dead-time triples is walked. It covers zero duty, duty above the period, dead time longer than the on-time and a plain mid-range duty. Over whole cycles it counts the high clocks on every gate, which separates correct compare and dead-time handling from off-by-one carriers. Advance-and-commute pulses are repeated through a full lap of the table and past the wrap, so table order and pointer wrap are told apart from a stuck or skipping sequencer. An advance without a commute shows that the shadow is isolated from the gates. A direct high-to-low transition on one phase, with the duty forced to full on, measures the dead-time gap clock by clock. A duty change made at the start of a cycle must not alter that cycle, which shows that the preload waits for the wrap.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    localparam int NPH   = 3;
    localparam int NSTEP = 6;
    localparam int SW    = $clog2(NSTEP);

    typedef logic [SW-1:0] step_idx_t;

    // one-hot phase selection per side: bit 0 = A, bit 1 = B, bit 2 = C
    typedef struct packed {
        logic [NPH-1:0] hi;
        logic [NPH-1:0] lo;
    } gate_sel_t;

    function automatic gate_sel_t step_sel(step_idx_t s);
        gate_sel_t g;
        case (s)
            SW'(0):  begin g.hi = 3'b001; g.lo = 3'b010; end
            SW'(1):  begin g.hi = 3'b001; g.lo = 3'b100; end
            SW'(2):  begin g.hi = 3'b010; g.lo = 3'b100; end
            SW'(3):  begin g.hi = 3'b010; g.lo = 3'b001; end
            SW'(4):  begin g.hi = 3'b100; g.lo = 3'b001; end
            SW'(5):  begin g.hi = 3'b100; g.lo = 3'b010; end
            default: begin g.hi = '0;     g.lo = '0;     end
        endcase
        return g;
    endfunction

    function automatic step_idx_t step_next(step_idx_t s);
        return (s == SW'(NSTEP - 1)) ? '0 : s + SW'(1);
    endfunction

endpackage

// File: rtl/sixstep_carrier.sv
module sixstep_carrier #(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 799
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             force_upd,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_ref
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cmp_act;
    logic             wrap;

    assign wrap    = run_en && (cnt >= per_act);
    assign pwm_ref = run_en && (cnt < cmp_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per_act <= CNT_W'(RST_PERIOD);
            cmp_act <= '0;
        end else begin
            if (!run_en || wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
            if (wrap || force_upd) begin
                per_act <= period_in;
                cmp_act <= duty_in;
            end
        end
    end
endmodule

// File: rtl/sixstep_sequencer.sv
module sixstep_sequencer
    import sixstep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_adv,
    input  logic      commute,
    output gate_sel_t active
);
    step_idx_t ptr;
    gate_sel_t shadow;
    step_idx_t ptr_nx;

    assign ptr_nx = step_next(ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            shadow <= step_sel('0);
            active <= '0;
        end else begin
            if (step_adv) begin
                ptr    <= ptr_nx;
                shadow <= step_sel(ptr_nx);
            end
            if (commute) begin
                active <= shadow;
            end
        end
    end
endmodule

// File: rtl/sixstep_deadband.sv
module sixstep_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [DT_W-1:0] dead,
    output logic            gate
);
    logic [DT_W-1:0] dly;

    // rising edge held back until the request has lasted 'dead' clocks
    assign gate = req && (dly >= dead);

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            dly <= '0;
        end else if (dly < dead) begin
            dly <= dly + DT_W'(1);
        end
    end
endmodule

// File: rtl/sixstep_pwm.sv
module sixstep_pwm
    import sixstep_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DT_W       = 8,
    parameter int RST_PERIOD = 799
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             moe,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DT_W-1:0]  dead_in,
    input  logic             force_upd,
    input  logic             step_adv,
    input  logic             commute,
    output logic [NPH-1:0]   gate_hi,
    output logic [NPH-1:0]   gate_lo
);
    logic      pwm_ref;
    logic      drive_ok;
    gate_sel_t active;

    assign drive_ok = moe && run_en;

    sixstep_carrier #(
        .CNT_W      (CNT_W),
        .RST_PERIOD (RST_PERIOD)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .force_upd (force_upd),
        .period_in (period_in),
        .duty_in   (duty_in),
        .pwm_ref   (pwm_ref)
    );

    sixstep_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .step_adv (step_adv),
        .commute  (commute),
        .active   (active)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic hi_req;
        logic lo_req;

        assign hi_req = drive_ok && active.hi[p] && pwm_ref;
        assign lo_req = drive_ok && active.lo[p];

        sixstep_deadband #(.DT_W(DT_W)) u_db_hi (
            .clk  (clk),
            .rst  (rst),
            .req  (hi_req),
            .dead (dead_in),
            .gate (gate_hi[p])
        );

        sixstep_deadband #(.DT_W(DT_W)) u_db_lo (
            .clk  (clk),
            .rst  (rst),
            .req  (lo_req),
            .dead (dead_in),
            .gate (gate_lo[p])
        );
    end
endmodule

// File: rtl/sixstep_chk.sv
module sixstep_chk
    import sixstep_pkg::*;
#(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            run_en,
    input logic            moe,
    input logic            commute,
    input logic [DT_W-1:0] dead_in,
    input logic [NPH-1:0]  gate_hi,
    input logic [NPH-1:0]  gate_lo,
    input gate_sel_t       active
);
    // R5: at most one high-side gate at a time
    p_single_hi_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_hi));

    // R5: at most one low-side gate at a time
    p_single_lo_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_lo));

    // R5: never both gates of one phase
    p_no_shoot_r5: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);

    // R4: the applied selection is always a legal table entry
    p_legal_sel_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active.hi) && $onehot0(active.lo) && ((active.hi & active.lo) == '0));

    // R10: gates idle low without master enable or run
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!moe || !run_en) |-> (gate_hi == '0 && gate_lo == '0));

    // R7: selection only changes after a commute strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !commute |=> $stable(active));

    // R9: a gate never turns on in the clock after its partner was on
    p_dead_lo_r9: assert property (@(posedge clk) disable iff (rst)
        (dead_in != '0) |-> ((gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0));

    p_dead_hi_r9: assert property (@(posedge clk) disable iff (rst)
        (dead_in != '0) |-> ((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0));
endmodule

bind sixstep_pwm sixstep_chk #(.DT_W(DT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .moe     (moe),
    .commute (commute),
    .dead_in (dead_in),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .active  (active)
);

// File: tb/sixstep_pwm_tb.sv
module sixstep_pwm_tb_top;
    localparam int CNT_W = 16;
    localparam int DT_W  = 8;
    localparam int NV    = 7;

    // period, compare, dead time, expected high-side clocks per cycle
    localparam int VEC [NV][4] = '{
        '{19,  5, 0,  5},
        '{19,  5, 2,  3},
        '{ 9,  0, 0,  0},
        '{ 9, 12, 2, 10},
        '{39, 20, 3, 17},
        '{19,  3, 5,  0},
        '{49, 25, 0, 25}
    };
    localparam int EXP_HI [6] = '{0, 0, 1, 1, 2, 2};
    localparam int EXP_LO [6] = '{1, 2, 2, 0, 0, 1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_en = 1'b0;
    logic             moe = 1'b0;
    logic [CNT_W-1:0] period_in = 16'd19;
    logic [CNT_W-1:0] duty_in = 16'd10;
    logic [DT_W-1:0]  dead_in = '0;
    logic             force_upd = 1'b0;
    logic             step_adv = 1'b0;
    logic             commute = 1'b0;
    logic [2:0]       gate_hi;
    logic [2:0]       gate_lo;

    int checks = 0;
    int errors = 0;
    int hc [3];
    int lc [3];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sixstep_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .moe       (moe),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .force_upd (force_upd),
        .step_adv  (step_adv),
        .commute   (commute),
        .gate_hi   (gate_hi),
        .gate_lo   (gate_lo)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_force();
        @(negedge clk) force_upd = 1'b1;
        @(negedge clk) force_upd = 1'b0;
    endtask

    task automatic pulse_adv();
        @(negedge clk) step_adv = 1'b1;
        @(negedge clk) step_adv = 1'b0;
    endtask

    task automatic pulse_com();
        @(negedge clk) commute = 1'b1;
        @(negedge clk) commute = 1'b0;
    endtask

    task automatic measure(int n);
        for (int p = 0; p < 3; p++) begin
            hc[p] = 0;
            lc[p] = 0;
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                hc[p] += int'(gate_hi[p]);
                lc[p] += int'(gate_lo[p]);
            end
        end
    endtask

    // compare windowed counts with one high phase and one low phase
    task automatic check_step(string tag, int hp, int lp, int hexp, int lexp);
        for (int p = 0; p < 3; p++) begin
            check({tag, " hi"}, hc[p], (p == hp) ? hexp : 0);
            check({tag, " lo"}, lc[p], (p == lp) ? lexp : 0);
        end
    endtask

    initial begin
        #900us;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int run_len;
        int gap;
        // R11: reset with drive enabled, no gate may move
        run_en = 1'b1;
        moe    = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 gates in reset", int'({gate_hi, gate_lo}), 0);
        rst = 1'b0;
        pulse_force();
        measure(60);
        check_step("R11 no commute yet", 9, 9, 0, 0);

        // R2 R9 R6: vector walk in step 0 (A high, B low)
        pulse_com();
        for (int v = 0; v < NV; v++) begin
            period_in = CNT_W'(VEC[v][0]);
            duty_in   = CNT_W'(VEC[v][1]);
            dead_in   = DT_W'(VEC[v][2]);
            pulse_force();
            repeat (3 * (VEC[v][0] + 1)) @(negedge clk);
            measure(4 * (VEC[v][0] + 1));
            check_step($sformatf("R2 R9 R6 vec%0d", v), 0, 1,
                       4 * VEC[v][3], 4 * (VEC[v][0] + 1));
        end

        // R4 R8 R5: full lap plus wrap
        do_reset();
        period_in = 16'd19;
        duty_in   = 16'd10;
        dead_in   = '0;
        pulse_force();
        pulse_com();
        repeat (20) @(negedge clk);
        measure(40);
        check_step("R4 step0", EXP_HI[0], EXP_LO[0], 20, 40);
        for (int i = 1; i <= 7; i++) begin
            pulse_adv();
            pulse_com();
            repeat (20) @(negedge clk);
            measure(40);
            check_step($sformatf("R4 R8 R5 step%0d", i % 6),
                       EXP_HI[i % 6], EXP_LO[i % 6], 20, 40);
        end

        // R7: advance without commute leaves step 1 applied
        pulse_adv();
        repeat (20) @(negedge clk);
        measure(40);
        check_step("R7 shadow held", EXP_HI[1], EXP_LO[1], 20, 40);
        pulse_com();
        repeat (20) @(negedge clk);
        measure(40);
        check_step("R7 shadow applied", EXP_HI[2], EXP_LO[2], 20, 40);

        // R10: master enable and run
        @(negedge clk) moe = 1'b0;
        @(negedge clk);
        check("R10 moe low", int'({gate_hi, gate_lo}), 0);
        moe = 1'b1;
        run_en = 1'b0;
        @(negedge clk);
        check("R10 run low", int'({gate_hi, gate_lo}), 0);
        run_en = 1'b1;

        // R9: A high straight to A low, full-on duty, dead 4
        do_reset();
        period_in = 16'd19;
        duty_in   = 16'd30;
        dead_in   = 8'd4;
        pulse_force();
        pulse_com();
        repeat (20) @(negedge clk);
        check("R9 A high before", int'(gate_hi[0]), 1);
        pulse_adv();
        pulse_adv();
        pulse_adv();
        @(negedge clk) commute = 1'b1;
        @(negedge clk) commute = 1'b0;
        check("R9 A high off", int'(gate_hi[0]), 0);
        check("R9 B low off", int'(gate_lo[1]), 0);
        check("R9 A low gap k0", int'(gate_lo[0]), 0);
        repeat (3) @(negedge clk);
        check("R9 A low gap k3", int'(gate_lo[0]), 0);
        @(negedge clk);
        check("R9 A low on k4", int'(gate_lo[0]), 1);
        check("R9 B high on k4", int'(gate_hi[1]), 1);

        // R3 R1: mid-cycle compare change waits for the wrap
        do_reset();
        period_in = 16'd99;
        duty_in   = 16'd50;
        dead_in   = '0;
        pulse_force();
        pulse_com();
        repeat (150) @(negedge clk);
        while (gate_hi[0]) @(negedge clk);
        while (!gate_hi[0]) @(negedge clk);
        duty_in = 16'd80;
        run_len = 0;
        gap = 0;
        while (gate_hi[0]) begin
            run_len++;
            gap++;
            @(negedge clk);
        end
        check("R3 old compare kept", run_len, 50);
        while (!gate_hi[0]) begin
            gap++;
            @(negedge clk);
        end
        check("R1 cycle length", gap, 100);
        run_len = 0;
        while (gate_hi[0]) begin
            run_len++;
            @(negedge clk);
        end
        check("R3 new compare at wrap", run_len, 80);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule